// File: doc/BRIEF.md
# Selectable LRC/CRC16 Block Check Unit

This block keeps the running block check value of a byte-oriented synchronous link. It has two independent contexts, one for transmit and one for receive. Each character arrives on a strobe together with a direction bit that names its context. A load strobe starts a message. It copies a preset value into the chosen context and fixes that context's algorithm for the message. The algorithm is either a longitudinal redundancy check (LRC, the XOR of all characters) or CRC16.

On transmit, the accumulator is presented without inversion so that framing logic can append it after the data. On receive, the check characters are fed through the same path as the data. Any residue other than zero then raises an error flag. The block also produces a parity bit for each character and checks it. This happens only while the link runs LRC outside transparent operation.

Top module: `blkchk_unit`

## Requirements
- R1: A load strobe (`load_i`=1) copies `preset_i` into the context named by `dir_i` (0 = transmit, 1 = receive). In the same edge it latches that context's algorithm as CRC16 when `mode_crc_i` | `transp_i` is 1, and as LRC otherwise. An LRC context keeps `preset_i[7:0]` and clears bits 15:8. `tx_crc_o` shows the latched algorithm of the transmit context. The result is visible one cycle after the strobe.
- R2: In LRC, each character strobe (`chr_vld_i`=1) XORs `chr_i` into the low 8 bits of the accumulator, and bits 15:8 stay zero. A preset of 0x00 gives even LRC and 0x00FF gives odd LRC.
- R3: In CRC16 (x^16+x^15+x^2+1), each character is shifted in bit 0 first, using the reflected form with constant 0xA001. Both 0x0000 and 0xFFFF are valid presets.
- R4: When `transp_i` is 1 at load, the context runs CRC16 even though `mode_crc_i` is 0.
- R5: `tx_bcs_o` is the transmit accumulator without inversion. The check characters follow the data as its low byte, then, for CRC16 only, its high byte.
- R6: `rx_err_o` is 1 when the receive residue is not zero. The residue is all 16 bits in CRC16 and bits 7:0 in LRC. After data and the correct check characters, with the same preset as transmit, it is 0.
- R7: `par_en_o` is 1 only when `mode_crc_i`=0 and `transp_i`=0. In that case `par_bit_o` makes the 9 bits {`chr_i`,`par_bit_o`} hold an odd number of ones. Otherwise `par_bit_o` is 0.
- R8: A receive character strobe with parity active and an even count of ones in {`chr_i`,`rx_par_i`} sets `par_err_o`. The flag is sticky until a receive load clears it. While parity is inactive, the received parity bit has no effect.
- R9: When a load and a character strobe arrive in the same cycle, the load wins and the character is not accumulated. A strobe to one context leaves the other unchanged.
- R10: After reset both accumulators are 0, both contexts are LRC, and `par_err_o` and `rx_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start of message: load preset into selected context |
| chr_vld_i | input | 1 | Character strobe |
| dir_i | input | 1 | Context select, 0 transmit, 1 receive |
| chr_i | input | 8 | Character |
| rx_par_i | input | 1 | Received parity bit of `chr_i` |
| mode_crc_i | input | 1 | 0 LRC, 1 CRC16 |
| transp_i | input | 1 | Transparent operation, forces CRC16 |
| preset_i | input | 16 | Accumulator preset |
| tx_bcs_o | output | 16 | Transmit check value |
| tx_crc_o | output | 1 | Transmit context runs CRC16 |
| rx_err_o | output | 1 | Receive residue not zero |
| par_bit_o | output | 1 | Generated parity for `chr_i` |
| par_en_o | output | 1 | Parity active |
| par_err_o | output | 1 | Sticky receive parity error |

## Verification
`par_bit_o` and `par_en_o` are combinational. The bench checks them in the same cycle the character is driven, before the clock edge. Accumulators, `tx_crc_o`, `rx_err_o` and `par_err_o` change on the edge that takes the strobe. The bench drives each strobe at a falling edge and reads these outputs at the next falling edge, which is one edge after the strobe. Expected check values come from a bitwise model in the bench that is applied per table entry.

// File: rtl/blkchk_pkg.sv
package blkchk_pkg;
    localparam int CHR_W   = 8;
    localparam int ACC_W   = 16;
    localparam int NCTX    = 2;
    localparam int CTX_TX  = 0;
    localparam int CTX_RX  = 1;
    localparam logic [ACC_W-1:0] POLY_REFL = 16'hA001;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             crc;
    } ctx_t;

    typedef struct packed {
        ctx_t [NCTX-1:0] ctx;
        logic            par_err;
    } state_t;
endpackage

// File: rtl/blkchk_step.sv
module blkchk_step
    import blkchk_pkg::*;
#(
    parameter logic [ACC_W-1:0] POLY = POLY_REFL
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [CHR_W-1:0] chr_i,
    input  logic             crc_i,
    output logic [ACC_W-1:0] nxt_o
);
    logic [ACC_W-1:0] crc_v;
    logic             fb;

    always_comb begin
        crc_v = acc_i;
        fb    = 1'b0;
        for (int b = 0; b < CHR_W; b++) begin
            fb    = crc_v[0] ^ chr_i[b];
            crc_v = crc_v >> 1;
            if (fb) crc_v = crc_v ^ POLY;
        end
        if (crc_i) nxt_o = crc_v;
        else       nxt_o = {{(ACC_W-CHR_W){1'b0}}, acc_i[CHR_W-1:0] ^ chr_i};
    end
endmodule

// File: rtl/blkchk_par.sv
module blkchk_par
    import blkchk_pkg::*;
#(
    parameter bit ODD = 1'b1
) (
    input  logic [CHR_W-1:0] chr_i,
    input  logic             act_i,
    input  logic             rx_bit_i,
    output logic             gen_o,
    output logic             bad_o
);
    always_comb begin
        gen_o = act_i ? ((^chr_i) ^ ODD) : 1'b0;
        bad_o = act_i && (((^chr_i) ^ rx_bit_i) != ODD);
    end
endmodule

// File: rtl/blkchk_unit.sv
module blkchk_unit
    import blkchk_pkg::*;
#(
    parameter bit ODD_PAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             chr_vld_i,
    input  logic             dir_i,
    input  logic [7:0]       chr_i,
    input  logic             rx_par_i,
    input  logic             mode_crc_i,
    input  logic             transp_i,
    input  logic [15:0]      preset_i,
    output logic [15:0]      tx_bcs_o,
    output logic             tx_crc_o,
    output logic             rx_err_o,
    output logic             par_bit_o,
    output logic             par_en_o,
    output logic             par_err_o
);
    state_t                      st_d, st_q;
    logic [NCTX-1:0][ACC_W-1:0]  step_nxt;
    logic                        par_act;
    logic                        par_bad;
    logic                        load_crc;

    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        blkchk_step #(.POLY(POLY_REFL)) u_step (
            .acc_i (st_q.ctx[g].acc),
            .chr_i (chr_i),
            .crc_i (st_q.ctx[g].crc),
            .nxt_o (step_nxt[g])
        );
    end

    assign par_act = !mode_crc_i && !transp_i;

    blkchk_par #(.ODD(ODD_PAR)) u_par (
        .chr_i    (chr_i),
        .act_i    (par_act),
        .rx_bit_i (rx_par_i),
        .gen_o    (par_bit_o),
        .bad_o    (par_bad)
    );

    always_comb begin
        st_d     = st_q;
        load_crc = mode_crc_i || transp_i;
        for (int c = 0; c < NCTX; c++) begin
            if (int'(dir_i) == c) begin
                if (load_i) begin
                    st_d.ctx[c].crc = load_crc;
                    st_d.ctx[c].acc = load_crc ? preset_i
                                    : {{(ACC_W-CHR_W){1'b0}}, preset_i[CHR_W-1:0]};
                end else if (chr_vld_i) begin
                    st_d.ctx[c].acc = step_nxt[c];
                end
            end
        end
        if (dir_i && load_i)               st_d.par_err = 1'b0;
        else if (dir_i && chr_vld_i && par_bad) st_d.par_err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_bcs_o  = st_q.ctx[CTX_TX].acc;
    assign tx_crc_o  = st_q.ctx[CTX_TX].crc;
    assign rx_err_o  = st_q.ctx[CTX_RX].crc ? (st_q.ctx[CTX_RX].acc != '0)
                                            : (st_q.ctx[CTX_RX].acc[CHR_W-1:0] != '0);
    assign par_en_o  = par_act;
    assign par_err_o = st_q.par_err;
endmodule

// File: rtl/blkchk_chk.sv
module blkchk_chk #(
    parameter bit ODD_PAR = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        load_i,
    input logic        chr_vld_i,
    input logic        dir_i,
    input logic [7:0]  chr_i,
    input logic        mode_crc_i,
    input logic        transp_i,
    input logic [15:0] preset_i,
    input logic [15:0] tx_bcs_o,
    input logic        tx_crc_o,
    input logic        par_bit_o,
    input logic        par_en_o,
    input logic        par_err_o
);
    p_tx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !dir_i) |=> (tx_crc_o == $past(mode_crc_i || transp_i)) &&
            (tx_bcs_o == ($past(mode_crc_i || transp_i) ? $past(preset_i)
                                                        : {8'h00, $past(preset_i[7:0])})));

    p_lrc_fold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld_i && !load_i && !dir_i && !tx_crc_o) |=>
            tx_bcs_o == {8'h00, $past(tx_bcs_o[7:0]) ^ $past(chr_i)});

    p_par_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_crc_i || transp_i) |-> (!par_en_o && !par_bit_o));

    p_par_odd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        par_en_o |-> ((^{chr_i, par_bit_o}) == ODD_PAR));

    p_par_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && dir_i) |=> !par_err_o);

    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_i || (!load_i && !chr_vld_i)) |=> $stable(tx_bcs_o) && $stable(tx_crc_o));
endmodule

bind blkchk_unit blkchk_chk #(.ODD_PAR(ODD_PAR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .chr_vld_i  (chr_vld_i),
    .dir_i      (dir_i),
    .chr_i      (chr_i),
    .mode_crc_i (mode_crc_i),
    .transp_i   (transp_i),
    .preset_i   (preset_i),
    .tx_bcs_o   (tx_bcs_o),
    .tx_crc_o   (tx_crc_o),
    .par_bit_o  (par_bit_o),
    .par_en_o   (par_en_o),
    .par_err_o  (par_err_o)
);

// File: tb/blkchk_unit_test.sv
module blkchk_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0, chr_vld_i = 1'b0, dir_i = 1'b0;
    logic [7:0]  chr_i = 8'h00;
    logic        rx_par_i = 1'b0, mode_crc_i = 1'b0, transp_i = 1'b0;
    logic [15:0] preset_i = 16'h0000;
    logic [15:0] tx_bcs_o;
    logic        tx_crc_o, rx_err_o, par_bit_o, par_en_o, par_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    blkchk_unit uut (.*);

    // entry: {mode, transp, preset[15:0], byte0, byte1, byte2}
    localparam int NV = 6;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h0000, 8'h31, 8'h32, 8'h33},
        {1'b0, 1'b0, 16'h00FF, 8'h31, 8'h32, 8'h33},
        {1'b1, 1'b0, 16'h0000, 8'hA5, 8'h5A, 8'h01},
        {1'b1, 1'b0, 16'hFFFF, 8'h00, 8'hFF, 8'h80},
        {1'b0, 1'b1, 16'h0000, 8'h12, 8'h34, 8'h56},
        {1'b1, 1'b1, 16'hFFFF, 8'hDE, 8'hAD, 8'hBE}
    };

    function automatic logic [15:0] ref_crc(input logic [15:0] a, input logic [7:0] d);
        logic [15:0] r = a;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ld(input logic d, input logic [15:0] p, input logic m, input logic t);
        @(negedge clk);
        dir_i = d; preset_i = p; mode_crc_i = m; transp_i = t; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic put(input logic d, input logic [7:0] c, input logic p);
        @(negedge clk);
        dir_i = d; chr_i = c; rx_par_i = p; chr_vld_i = 1'b1;
        @(negedge clk);
        chr_vld_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] e;
        logic        crc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 tx_bcs", tx_bcs_o, 0);
        chk("R10 tx_crc", tx_crc_o, 0);
        chk("R10 rx_err", rx_err_o, 0);
        chk("R10 par_err", par_err_o, 0);

        for (int v = 0; v < NV; v++) begin
            logic [41:0] w = VEC[v];
            logic [7:0]  bytes [3];
            bytes[0] = w[23:16]; bytes[1] = w[15:8]; bytes[2] = w[7:0];
            crc = w[41] | w[40];
            e   = crc ? w[39:24] : {8'h00, w[31:24]};
            ld(1'b0, w[39:24], w[41], w[40]);
            chk("R1 R4 tx mode", tx_crc_o, crc);
            chk("R1 tx preset", tx_bcs_o, e);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                dir_i = 1'b0; chr_i = bytes[k]; chr_vld_i = 1'b1;
                #1;
                chk("R7 par_en", par_en_o, !w[41] && !w[40]);
                chk("R7 par_bit", par_bit_o, (!w[41] && !w[40]) ? ~^bytes[k] : 1'b0);
                @(negedge clk);
                chr_vld_i = 1'b0;
                e = crc ? ref_crc(e, bytes[k]) : {8'h00, e[7:0] ^ bytes[k]};
            end
            chk(crc ? "R3 R5 crc value" : "R2 R5 lrc value", tx_bcs_o, e);
            // receive with appended check chars, low byte first
            ld(1'b1, w[39:24], w[41], w[40]);
            for (int k = 0; k < 3; k++) put(1'b1, bytes[k], ~^bytes[k]);
            put(1'b1, e[7:0], ~^e[7:0]);
            if (crc) put(1'b1, e[15:8], 1'b0);
            chk("R6 residue clean", rx_err_o, 0);
            chk("R9 tx kept", tx_bcs_o, e);
            put(1'b1, 8'h01, 1'b0);
            chk("R6 residue bad", rx_err_o, 1);
        end

        // R8 parity error sticky, cleared on rx load
        ld(1'b1, 16'h0000, 1'b0, 1'b0);
        chk("R8 cleared", par_err_o, 0);
        put(1'b1, 8'h01, 1'b1);
        chk("R8 set", par_err_o, 1);
        put(1'b1, 8'h03, 1'b1);
        chk("R8 sticky", par_err_o, 1);
        ld(1'b1, 16'h0000, 1'b0, 1'b0);
        chk("R8 load clears", par_err_o, 0);
        // R8 ignored while parity inactive
        ld(1'b1, 16'h0000, 1'b1, 1'b0);
        put(1'b1, 8'h01, 1'b1);
        chk("R8 crc ignores parity", par_err_o, 0);
        ld(1'b1, 16'h0000, 1'b0, 1'b1);
        put(1'b1, 8'h01, 1'b1);
        chk("R8 transparent ignores parity", par_err_o, 0);
        // R9 load wins over character in the same cycle
        @(negedge clk);
        dir_i = 1'b0; preset_i = 16'h00A0; mode_crc_i = 1'b0; transp_i = 1'b0;
        load_i = 1'b1; chr_vld_i = 1'b1; chr_i = 8'h55;
        @(negedge clk);
        load_i = 1'b0; chr_vld_i = 1'b0;
        chk("R9 load priority", tx_bcs_o, 16'h00A0);
        // R2 LRC drops upper preset bits
        ld(1'b0, 16'hABFF, 1'b0, 1'b0);
        chk("R2 lrc preset upper", tx_bcs_o, 16'h00FF);
        // R4 transparent with LRC selected runs CRC16
        ld(1'b0, 16'h0000, 1'b0, 1'b1);
        put(1'b0, 8'h01, 1'b0);
        chk("R4 forced crc", tx_bcs_o, ref_crc(16'h0000, 8'h01));
        finish_run();
    end
endmodule